// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a configuration port for a mixed-signal device. A host reaches a bank of byte-wide or halfword-wide control registers over a slow serial link. The link has an active-low select, a serial clock and one data line. Each frame starts with an instruction byte that carries the transfer direction and a register address, and a single data word follows it. Both go most significant bit first. Register writes are held back until the select line returns high, so a partial frame leaves every register as it was.

The port has two wiring modes. In the default three-wire mode the data line is shared: the block turns its driver on only while it returns read data. Setting a control bit selects four-wire mode. The data line then becomes input only, and read data leaves on the alarm pin instead. Outside a read, that pin carries the alarm level: the OR of the alarm sources that the mask register enables, shown active low by default or active high when the polarity bit is set. A temperature value supplied from outside can be read at a fixed address.

The serial lines are oversampled by the block clock, which must run at least several times faster than the serial clock.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset the control word (address 0) is zero, so the port is in three-wire mode with an active-low alarm. The mask word (address 1) has its low NALARM bits set and its other bits clear. All other stored words are zero, `sdio_oe` is 0 and the alarm pin idles high.
- R2: A frame is 8+DW serial-clock rising edges long. The bits are sampled on rising edges, most significant bit first: an instruction byte (bit 7 = 1 for read, bits 4:0 = address, bits 6:5 ignored), then the data word. A write frame changes the addressed word only once `sen_n` returns high, never before.
- R3: If `sen_n` rises after fewer than 8+DW rising edges, no register changes.
- R4: In three-wire mode a read drives the addressed word on `sdio_out`, most significant bit first. Each bit appears after a serial-clock falling edge, starting with the falling edge that follows the eighth rising edge. `sdio_oe` is 1 only from that falling edge until `sen_n` rises, and it is 0 during every instruction phase and every write.
- R5: A read returns the current content of the addressed word. Address 2 returns `temp_val`, and writes to address 2 are ignored.
- R6: With bit 0 of the control word set (four-wire mode), `sdio_oe` stays 0 and the read data word appears on `alarm_sdo` with the timing of R4.
- R7: Outside a read data phase, `alarm_sdo` carries the OR of `alarm_src` bits that are enabled by the matching mask bits. It is active low when control bit 1 is 0 and active high when that bit is 1.
- R8: A read frame changes no register.
- R9: Addresses at or above NREG read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_n | input | 1 | Active-low serial select that frames a transaction |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Level seen on the serial data line |
| sdio_out | output | 1 | Read data for the serial data line |
| sdio_oe | output | 1 | Driver enable for the serial data line (three-wire read data phase) |
| alarm_sdo | output | 1 | Alarm level, or read data in four-wire mode |
| temp_val | input | DW | Temperature value returned at address 2 |
| alarm_src | input | NALARM | Alarm sources, one bit each |
| cfg_regs | output | NREG*DW | All register words, word i at bits i*DW upward (word 2 reads as zero here) |

## Verification
The bench starts with directed frames. A write followed by a read-back at an ordinary address shows that the shifting order and the commit at the end of the frame are right. Frames cut off after 7 and 12 bits separate an abort from a commit. Writes to the temperature address and to unmapped addresses show which addresses are read-only and which are absent. The alarm is checked across combinations of source and mask with both polarities, which separates masking from polarity. A pass in four-wire mode shows that read data is routed to the alarm pin and that the shared line is never driven. After that, seeded random reads, writes and aborts run at random addresses with random ignored instruction bits. Because these can also rewrite the mode and mask words, the data-line enable and the read-data routing are checked while the modes change from frame to frame.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

   localparam int INSTR_W = 8;
   localparam int ADDR_W  = 5;
   localparam int RW_BIT  = 7;

   localparam int A_CTRL  = 0;
   localparam int A_MASK  = 1;
   localparam int A_TEMP  = 2;

   localparam int B_FOURW = 0;
   localparam int B_POL   = 1;

   function automatic logic [15:0] rst_word(input int idx, input int nalarm);
      logic [16:0] ones;
      ones = (17'd1 << nalarm) - 17'd1;
      if (idx == A_MASK) return ones[15:0];
      return 16'h0000;
   endfunction

endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stg
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      stg[s] <= RST_VAL;
               else if (s == 0) stg[s] <= d;
               else             stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/cfg_frame_eng.sv
module cfg_frame_eng
   import cfg_port_pkg::*;
#(
   parameter int DW    = 8,
   localparam int FRAME = INSTR_W + DW,
   localparam int CW    = $clog2(FRAME + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sen_s,
   input  logic               sclk_s,
   input  logic               sdi_s,
   input  logic [DW-1:0]      rdata,
   output logic [INSTR_W-1:0] instr,
   output logic [DW-1:0]      dat,
   output logic [CW-1:0]      cnt,
   output logic               sen_rise,
   output logic               wr_en,
   output logic               rd_act,
   output logic               sdo
);

   logic          sclk_q, sen_q;
   logic          rise, fall;
   logic [DW-1:0] rd_sh;

   assign rise     = sclk_s & ~sclk_q;
   assign fall     = ~sclk_s & sclk_q;
   assign sen_rise = sen_s & ~sen_q;
   assign wr_en    = sen_rise && (cnt == CW'(FRAME)) && !instr[RW_BIT];
   assign sdo      = rd_sh[DW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         sen_q  <= 1'b1;
      end else begin
         sclk_q <= sclk_s;
         sen_q  <= sen_s;
      end
   end

   // bit counter and capture registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         instr <= '0;
         dat   <= '0;
      end else if (sen_s) begin
         cnt <= '0;
      end else if (rise && (cnt < CW'(FRAME))) begin
         if (cnt < CW'(INSTR_W)) instr <= {instr[INSTR_W-2:0], sdi_s};
         else                    dat   <= {dat[DW-2:0], sdi_s};
         cnt <= cnt + 1'b1;
      end
   end

   // read return path, advanced on falling serial edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_act <= 1'b0;
         rd_sh  <= '0;
      end else if (sen_s) begin
         rd_act <= 1'b0;
      end else if (fall) begin
         if (!rd_act && (cnt == CW'(INSTR_W)) && instr[RW_BIT]) begin
            rd_act <= 1'b1;
            rd_sh  <= rdata;
         end else if (rd_act) begin
            rd_sh  <= {rd_sh[DW-2:0], 1'b0};
         end
      end
   end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
   import cfg_port_pkg::*;
#(
   parameter int DW     = 8,
   parameter int NREG   = 24,
   parameter int NALARM = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DW-1:0]     temp_in,
   output logic [DW-1:0]     rd_data,
   output logic [DW-1:0]     ctrl_word,
   output logic [DW-1:0]     mask_word,
   output logic [NREG*DW-1:0] flat
);

   logic [DW-1:0] store [NREG];

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_word
         if (g == A_TEMP) begin : g_ro
            assign store[g] = '0;
         end else begin : g_rw
            localparam logic [15:0] RV = rst_word(g, NALARM);
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  store[g] <= RV[DW-1:0];
               else if (wr_en && (wr_addr == ADDR_W'(g)))
                  store[g] <= wr_data;
            end
         end
         assign flat[g*DW +: DW] = store[g];
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(A_TEMP)) begin
         rd_data = temp_in;
      end else begin
         for (int i = 0; i < NREG; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = store[i];
      end
   end

   assign ctrl_word = store[A_CTRL];
   assign mask_word = store[A_MASK];

endmodule

// File: rtl/cfg_alarm_mux.sv
module cfg_alarm_mux #(
   parameter int NALARM = 4
) (
   input  logic [NALARM-1:0] src,
   input  logic [NALARM-1:0] mask,
   input  logic              pol_high,
   input  logic              four_wire,
   input  logic              rd_act,
   input  logic              sdo,
   output logic              pin
);

   logic raw, level;

   assign raw   = |(src & mask);
   assign level = pol_high ? raw : ~raw;
   assign pin   = (four_wire && rd_act) ? sdo : level;

endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
   import cfg_port_pkg::*;
#(
   parameter int DW     = 8,
   parameter int NREG   = 24,
   parameter int NALARM = 4,
   parameter int SYNC   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sen_n,
   input  logic               sclk,
   input  logic               sdio_in,
   output logic               sdio_out,
   output logic               sdio_oe,
   output logic               alarm_sdo,
   input  logic [DW-1:0]      temp_val,
   input  logic [NALARM-1:0]  alarm_src,
   output logic [NREG*DW-1:0] cfg_regs
);

   localparam int FRAME = INSTR_W + DW;
   localparam int CW    = $clog2(FRAME + 1);

   generate
      if (!(DW == 8 || DW == 16)) begin : g_bad_dw
         $error("spi_cfg_port: DW must be 8 or 16");
      end
      if (NREG <= A_TEMP || NREG > (1 << ADDR_W)) begin : g_bad_nreg
         $error("spi_cfg_port: NREG out of range");
      end
      if (NALARM < 1 || NALARM > DW) begin : g_bad_nalarm
         $error("spi_cfg_port: NALARM must be 1..DW");
      end
      if (SYNC < 0 || SYNC > 4) begin : g_bad_sync
         $error("spi_cfg_port: SYNC must be 0..4");
      end
   endgenerate

   logic               sen_s, sclk_s, sdi_s;
   logic [INSTR_W-1:0] instr;
   logic [DW-1:0]      dat, rdata, ctrl_word, mask_word;
   logic [CW-1:0]      cnt;
   logic               sen_rise, wr_en, rd_act, sdo;
   logic               four_wire, alarm_pol;
   logic               unused_bits;

   sig_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sen_n, sclk, sdio_in}),
      .q     ({sen_s, sclk_s, sdi_s})
   );

   cfg_frame_eng #(.DW(DW)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .sen_s    (sen_s),
      .sclk_s   (sclk_s),
      .sdi_s    (sdi_s),
      .rdata    (rdata),
      .instr    (instr),
      .dat      (dat),
      .cnt      (cnt),
      .sen_rise (sen_rise),
      .wr_en    (wr_en),
      .rd_act   (rd_act),
      .sdo      (sdo)
   );

   cfg_reg_bank #(.DW(DW), .NREG(NREG), .NALARM(NALARM)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (instr[ADDR_W-1:0]),
      .wr_data   (dat),
      .rd_addr   (instr[ADDR_W-1:0]),
      .temp_in   (temp_val),
      .rd_data   (rdata),
      .ctrl_word (ctrl_word),
      .mask_word (mask_word),
      .flat      (cfg_regs)
   );

   assign four_wire = ctrl_word[B_FOURW];
   assign alarm_pol = ctrl_word[B_POL];

   cfg_alarm_mux #(.NALARM(NALARM)) u_alarm (
      .src       (alarm_src),
      .mask      (mask_word[NALARM-1:0]),
      .pol_high  (alarm_pol),
      .four_wire (four_wire),
      .rd_act    (rd_act),
      .sdo       (sdo),
      .pin       (alarm_sdo)
   );

   assign sdio_out    = sdo;
   assign sdio_oe     = rd_act & ~four_wire;
   assign unused_bits = ^{instr[RW_BIT-1:ADDR_W], ctrl_word, mask_word};

endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
   parameter int DW   = 8,
   parameter int NREG = 24,
   parameter int CW   = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sen_rise,
   input logic [CW-1:0]      cnt,
   input logic               instr7,
   input logic               sdio_oe,
   input logic               four_wire,
   input logic [NREG*DW-1:0] cfg_regs
);

   localparam int FRAME = 8 + DW;

   p_oe_in_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sdio_oe |-> (instr7 && (cnt >= CW'(8))));

   p_oe_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sen_rise |=> !sdio_oe);

   p_no_drive_4w_r6: assert property (@(posedge clk) disable iff (!rst_n)
      four_wire |-> !sdio_oe);

   p_hold_until_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sen_rise |=> $stable(cfg_regs));

   p_abort_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sen_rise && (cnt != CW'(FRAME))) |=> $stable(cfg_regs));

   p_read_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sen_rise && instr7) |=> $stable(cfg_regs));

endmodule

bind spi_cfg_port cfg_port_chk #(.DW(DW), .NREG(NREG), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sen_rise  (sen_rise),
   .cnt       (cnt),
   .instr7    (instr[7]),
   .sdio_oe   (sdio_oe),
   .four_wire (four_wire),
   .cfg_regs  (cfg_regs)
);

// File: tb/sim_spi_cfg_port.sv
`timescale 1ns/1ps
module sim_spi_cfg_port;

   localparam int DW = 8, NREG = 24, NALARM = 4, HALF = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sen_n = 1'b1, sclk = 1'b0, sdio_in = 1'b0;
   logic sdio_out, sdio_oe, alarm_sdo;
   logic [DW-1:0] temp_val = 8'h5C;
   logic [NALARM-1:0] alarm_src = '0;
   logic [NREG*DW-1:0] cfg_regs;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [7:0] m [NREG];

   always #2 clk = ~clk;

   spi_cfg_port #(.DW(DW), .NREG(NREG), .NALARM(NALARM), .SYNC(2)) u0 (
      .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sclk(sclk), .sdio_in(sdio_in),
      .sdio_out(sdio_out), .sdio_oe(sdio_oe), .alarm_sdo(alarm_sdo),
      .temp_val(temp_val), .alarm_src(alarm_src), .cfg_regs(cfg_regs));

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [4:0] a);
      if (a == 5'd2) return temp_val;
      if (a < 5'(NREG)) return m[a];
      return 8'h00;
   endfunction

   function automatic bit exp_alarm();
      logic raw;
      raw = |(alarm_src & m[1][NALARM-1:0]);
      return m[0][1] ? raw : !raw;
   endfunction

   function automatic bit slots_match();
      for (int i = 0; i < NREG; i++)
         if (cfg_regs[i*8 +: 8] !== m[i]) return 0;
      return 1;
   endfunction

   task automatic op(input bit rd, input logic [4:0] a, input logic [7:0] d, input int nbits,
                     input string req);
      logic [15:0] fr;
      logic [7:0] got;
      logic [NREG*DW-1:0] snap;
      bit oe_bad, fw;
      fr = {rd, 2'($urandom), a, d};
      got = '0; oe_bad = 0; fw = m[0][0]; snap = cfg_regs;
      sen_n = 1'b0;
      tick(HALF);
      for (int i = 0; i < nbits; i++) begin
         sdio_in = fr[15-i];
         tick(HALF);
         if (i < 8 || !rd) begin
            if (sdio_oe !== 1'b0) oe_bad = 1;
         end else begin
            if (sdio_oe !== !fw) oe_bad = 1;
            got = {got[6:0], fw ? alarm_sdo : sdio_out};
         end
         sclk = 1'b1;
         tick(HALF);
         sclk = 1'b0;
      end
      tick(HALF);
      if (!rd && nbits == 16)
         chk(cfg_regs === snap, "R2 no change before select rises", cfg_regs[63:0], snap[63:0]);
      sen_n = 1'b1;
      tick(12);
      if (rd && nbits == 16)
         chk(got === exp_read(a), {req, " R5 read data"}, got, exp_read(a));
      chk(!oe_bad, fw ? "R6 line enable in 4-wire" : "R4 line enable window", oe_bad, 0);
      if (!rd && nbits == 16 && a < 5'(NREG) && a != 5'd2) m[a] = d;
      chk(slots_match(), {req, " register contents"}, cfg_regs[63:0], 0);
      chk(sdio_oe === 1'b0, "R4 enable off when idle", sdio_oe, 0);
   endtask

   initial begin
      logic [4:0] a;
      int k;
      void'($urandom(32'd4021));
      for (int i = 0; i < NREG; i++) m[i] = 8'h00;
      m[1] = 8'h0F;
      tick(5);
      rst_n = 1'b1;
      tick(5);
      // R1 reset state
      chk(slots_match(), "R1 reset words", cfg_regs[63:0], 64'h0F00);
      chk(sdio_oe === 1'b0, "R1 enable at reset", sdio_oe, 0);
      chk(alarm_sdo === 1'b1, "R1 alarm idle high", alarm_sdo, 1);
      // R2 write then read back
      op(0, 5'd5, 8'hA5, 16, "R2 write");
      op(1, 5'd5, 8'h00, 16, "R8 read");
      // R3 aborted frames
      op(0, 5'd5, 8'h3C, 12, "R3 abort in data");
      op(0, 5'd6, 8'h77, 7, "R3 abort in instr");
      op(1, 5'd5, 8'h00, 16, "R3 read after abort");
      // R5 temperature address is read-only
      op(0, 5'd2, 8'h33, 16, "R5 write temp");
      op(1, 5'd2, 8'h00, 16, "R5 read temp");
      // R7 alarm masking and polarity
      alarm_src = 4'b0010; tick(4);
      chk(alarm_sdo === exp_alarm(), "R7 active low asserted", alarm_sdo, exp_alarm());
      op(0, 5'd1, 8'h0D, 16, "R7 mask");
      chk(alarm_sdo === 1'b1, "R7 masked source", alarm_sdo, 1);
      op(0, 5'd0, 8'h02, 16, "R7 polarity");
      chk(alarm_sdo === 1'b0, "R7 active high idle", alarm_sdo, 0);
      alarm_src = 4'b0001; tick(4);
      chk(alarm_sdo === 1'b1, "R7 active high asserted", alarm_sdo, 1);
      // R6 four-wire mode
      op(0, 5'd0, 8'h03, 16, "R6 enter 4-wire");
      op(1, 5'd5, 8'h00, 16, "R6 read on alarm pin");
      chk(alarm_sdo === exp_alarm(), "R6 alarm restored", alarm_sdo, exp_alarm());
      op(0, 5'd0, 8'h00, 16, "R6 leave 4-wire");
      // R9 unmapped addresses
      op(0, 5'd30, 8'hEE, 16, "R9 write unmapped");
      op(1, 5'd30, 8'h00, 16, "R9 read unmapped");
      // random mix
      for (int n = 0; n < 60; n++) begin
         a = 5'($urandom_range(0, 31));
         k = $urandom_range(0, 9);
         alarm_src = 4'($urandom);
         temp_val = 8'($urandom);
         if (k < 4)      op(1, a, 8'h00, 16, "R5 random read");
         else if (k < 8) op(0, a, 8'($urandom), 16, "R2 random write");
         else            op(0, a, 8'($urandom), $urandom_range(1, 15), "R3 random abort");
         chk(alarm_sdo === exp_alarm(), "R7 random alarm", alarm_sdo, exp_alarm());
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule